// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave side of a three-wire serial link into a bank of configuration registers whose widths differ from one register to the next. The master pulls an active-low select low to open a frame, then clocks in a 4-bit register address, most significant bit first, followed by a direction bit. A direction bit of 0 starts a read. The slave turns the single data line around inside the frame and shifts the chosen register out, top bit first. A direction bit of 1 starts a write. The master then clocks in the register's bits, and the slave commits them when the select is released.

The serial pins are oversampled by the system clock through two-flop synchronizers and edge detectors, so the whole block runs on one clock. The data pin is split into an input, an output and an output enable; the pad itself sits outside the block. Every register's current value is driven as a plain level on a flat parallel bus. The serial pins follow a fixed framing, and the parallel bus has no handshake, so neither has back-pressure. Register widths (1 to MAXW bits) and the valid-address mask are parameters. By default, addresses 0 to 7 are valid, with widths 10, 32, 8, 16, 1, 24, 12 and 4 bits, and addresses 8 to 15 are invalid.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, ser_doe and ser_dout are 0 and every register on regs_flat reads 0.
- R2: A frame opens on a falling ser_sel_n. The next four rising ser_clk edges sample the address, most significant bit first. The fifth rising edge samples the direction bit, where 0 means read and 1 means write.
- R3: ser_doe stays 0 through the address bits and through the high phase of the direction bit. In a read, it rises on the falling ser_clk edge that follows the direction bit, and it is 1 only during a read.
- R4: In a read of a valid register of width W, the falling ser_clk edges present bits W-1 down to 0, one per edge. The first of these is the edge that enables the output.
- R5: After all W bits of a valid register have been presented, every later falling edge of the frame presents 0.
- R6: In a read of an invalid address, the first 32 falling edges of the data phase present 1 and every later one presents 0.
- R7: Raising ser_sel_n ends the frame at any bit, including inside the address. ser_doe returns to 0 within a few system clocks, and the next frame restarts its address and data bit counts from zero.
- R8: In a write, rising ser_clk edges sample the data bits, most significant bit first. When ser_sel_n rises, the addressed register takes the received value only if exactly W bits arrived. Bits above W read as 0 on regs_flat.
- R9: A write with more or fewer than W bits, or a write to an invalid address, leaves every register unchanged. ser_doe stays 0 throughout a write.
- R10: Register k appears on regs_flat bits [k*MAXW +: MAXW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Active-low frame select from the master |
| ser_clk | input | 1 | Serial bit clock from the master |
| ser_din | input | 1 | Data line as seen by the slave |
| ser_dout | output | 1 | Read data driven toward the data line |
| ser_doe | output | 1 | Output enable for the data line pad |
| regs_flat | output | 2**ADDR_W*MAXW | All registers side by side, register k at [k*MAXW +: MAXW] |

## Verification
The bench drives frames bit by bit and samples the data output late in each low phase of the serial clock. It follows every read past the register's width, so a design that wraps round or repeats the last bit instead of sending zeros is caught. It reads invalid addresses for 36 bits, which exposes a wrong count of ones or an off-by-one at the 32nd period. It aborts frames both inside the address and partway through the data, then runs a full read at once, which catches counters that are not cleared and an output enable that is never released. It also writes with one bit too few and one bit too many and writes to an invalid address, then compares the whole parallel bus, which catches a commit that ignores the bit count or leaks into a neighbouring register.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int unsigned WIDTH_FIELD   = 8;
  localparam int unsigned BAD_ADDR_ONES = 32;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DIR,
    PH_READ,
    PH_WRITE
  } phase_e;
endpackage

// File: rtl/tws_pin_sync.sv
module tws_pin_sync #(
  parameter int unsigned      N        = 3,
  parameter int unsigned      STAGES   = 2,
  parameter logic [N-1:0]     IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= IDLE_VAL;
        else        chain[s] <= raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= IDLE_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= IDLE_VAL;
    else        prev <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tws_frame_ctrl.sv
module tws_frame_ctrl
  import tws_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MAXW   = 32,
  parameter int unsigned CW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_begin,
  input  logic              frame_end,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic              sel_valid,
  input  logic [CW-1:0]     sel_width,
  output logic [ADDR_W-1:0] addr,
  output logic              oe,
  output logic              rd_step,
  output logic              rd_first,
  output logic [MAXW-1:0]   wbuf,
  output logic              commit
);
  localparam int unsigned HC_W = $clog2(ADDR_W) + 1;

  phase_e            phase;
  logic [HC_W-1:0]   hcnt;
  logic [CW-1:0]     wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      hcnt   <= '0;
      addr   <= '0;
      oe     <= 1'b0;
      wbuf   <= '0;
      wcnt   <= '0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (frame_end) begin
        commit <= (phase == PH_WRITE) && sel_valid && (wcnt == sel_width);
        phase  <= PH_IDLE;
        oe     <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: if (frame_begin) begin
            phase <= PH_ADDR;
            hcnt  <= '0;
          end
          PH_ADDR: if (sck_rise) begin
            addr <= {addr[ADDR_W-2:0], din};
            hcnt <= hcnt + 1'b1;
            if (hcnt == HC_W'(ADDR_W - 1)) phase <= PH_DIR;
          end
          PH_DIR: if (sck_rise) begin
            phase <= din ? PH_WRITE : PH_READ;
            wcnt  <= '0;
            wbuf  <= '0;
          end
          PH_READ: if (sck_fall) oe <= 1'b1;
          PH_WRITE: if (sck_rise) begin
            wbuf <= {wbuf[MAXW-2:0], din};
            if (wcnt != '1) wcnt <= wcnt + 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign rd_step  = (phase == PH_READ) && sck_fall && !frame_end;
  assign rd_first = rd_step && !oe;

  // R3: the pad is driven only while a read frame is open
  assert_oe_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (phase == PH_READ));

  // R9: a write frame never enables the pad
  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE) |=> !oe);
endmodule

// File: rtl/tws_read_gen.sv
module tws_read_gen
  import tws_pkg::*;
#(
  parameter int unsigned MAXW = 32,
  parameter int unsigned CW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            first,
  input  logic            sel_valid,
  input  logic [CW-1:0]   sel_width,
  input  logic [MAXW-1:0] sel_data,
  output logic            dout
);
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   idx;
  logic [CW-1:0]   pos;
  logic [MAXW-1:0] shifted;
  logic            nxt;

  always_comb begin
    idx     = first ? '0 : cnt;
    pos     = sel_width - idx - 1'b1;
    shifted = sel_data >> pos;
    if (sel_valid) nxt = (idx < sel_width) ? shifted[0] : 1'b0;
    else           nxt = (idx < CW'(BAD_ADDR_ONES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (step) begin
      dout <= nxt;
      cnt  <= (idx == '1) ? idx : idx + 1'b1;
    end
  end

  // R4: the output moves only on a data-phase falling edge
  assert_change_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(step));

  // R5: past the register width the line reads zero
  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sel_valid && (idx >= sel_width)) |=> !dout);

  // R6: an unknown address yields ones for the first 32 periods
  assert_bad_addr_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_valid && (idx < CW'(BAD_ADDR_ONES))) |=> dout);
endmodule

// File: rtl/tws_reg_bank.sv
module tws_reg_bank
  import tws_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MAXW   = 32,
  parameter int unsigned CW     = 7,
  parameter logic [(2**ADDR_W)*WIDTH_FIELD-1:0] WIDTHS = '0,
  parameter logic [(2**ADDR_W)-1:0]             VALID  = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [MAXW-1:0]               wdata,
  output logic                          sel_valid,
  output logic [CW-1:0]                 sel_width,
  output logic [MAXW-1:0]               sel_data,
  output logic [(2**ADDR_W)*MAXW-1:0]   regs_flat
);
  localparam int unsigned NREG = 2 ** ADDR_W;

  logic [MAXW-1:0] dat_a [NREG];
  logic [CW-1:0]   wid_a [NREG];
  logic [NREG-1:0] val_a;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam int unsigned WK = int'(WIDTHS[k*WIDTH_FIELD +: WIDTH_FIELD]);
    localparam logic [MAXW-1:0] MK =
      (WK >= MAXW) ? {MAXW{1'b1}} : MAXW'((64'd1 << WK) - 64'd1);
    if (VALID[k] && (WK > 0)) begin : g_live
      logic [MAXW-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                             q <= '0;
        else if (commit && addr == ADDR_W'(k))  q <= wdata & MK;
      assign dat_a[k] = q;
      assign val_a[k] = 1'b1;
      assign wid_a[k] = CW'(WK);
    end else begin : g_hole
      assign dat_a[k] = '0;
      assign val_a[k] = 1'b0;
      assign wid_a[k] = '0;
    end
    assign regs_flat[k*MAXW +: MAXW] = dat_a[k];
  end

  assign sel_valid = val_a[addr];
  assign sel_width = wid_a[addr];
  assign sel_data  = dat_a[addr];

  // R9: registers move only on a commit pulse
  assert_hold_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_flat));

  // R9: a commit aimed at an invalid address changes nothing
  assert_bad_addr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !sel_valid) |=> $stable(regs_flat));
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
  import tws_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MAXW   = 32,
  parameter logic [(2**ADDR_W)*WIDTH_FIELD-1:0] REG_WIDTHS =
    {64'h0, 8'd4, 8'd12, 8'd24, 8'd1, 8'd16, 8'd8, 8'd32, 8'd10},
  parameter logic [(2**ADDR_W)-1:0] REG_VALID = 16'h00FF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_sel_n,
  input  logic                        ser_clk,
  input  logic                        ser_din,
  output logic                        ser_dout,
  output logic                        ser_doe,
  output logic [(2**ADDR_W)*MAXW-1:0] regs_flat
);
  localparam int unsigned SPAN = ((MAXW > BAD_ADDR_ONES) ? MAXW : BAD_ADDR_ONES) + 1;
  localparam int unsigned CW   = $clog2(SPAN) + 1;

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic       sck_rise, sck_fall, frame_begin, frame_end, din_s;
  logic       sel_valid, rd_step, rd_first, commit;
  logic [CW-1:0]     sel_width;
  logic [MAXW-1:0]   sel_data, wbuf;
  logic [ADDR_W-1:0] addr;
  logic              unused_pins;

  tws_pin_sync #(.N(3), .STAGES(2), .IDLE_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({ser_din, ser_sel_n, ser_clk}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign sck_rise    = pin_rise[0];
  assign sck_fall    = pin_fall[0];
  assign frame_begin = pin_fall[1];
  assign frame_end   = pin_rise[1];
  assign din_s       = pin_lvl[2];
  assign unused_pins = ^{pin_lvl[1:0], pin_rise[2], pin_fall[2]};

  tws_frame_ctrl #(.ADDR_W(ADDR_W), .MAXW(MAXW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_begin(frame_begin),
    .frame_end  (frame_end),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .din        (din_s),
    .sel_valid  (sel_valid),
    .sel_width  (sel_width),
    .addr       (addr),
    .oe         (ser_doe),
    .rd_step    (rd_step),
    .rd_first   (rd_first),
    .wbuf       (wbuf),
    .commit     (commit)
  );

  tws_reg_bank #(
    .ADDR_W(ADDR_W), .MAXW(MAXW), .CW(CW),
    .WIDTHS(REG_WIDTHS), .VALID(REG_VALID)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .addr     (addr),
    .wdata    (wbuf),
    .sel_valid(sel_valid),
    .sel_width(sel_width),
    .sel_data (sel_data),
    .regs_flat(regs_flat)
  );

  tws_read_gen #(.MAXW(MAXW), .CW(CW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (rd_step),
    .first    (rd_first),
    .sel_valid(sel_valid),
    .sel_width(sel_width),
    .sel_data (sel_data),
    .dout     (ser_dout)
  );

  // R7: releasing the select drops the output enable on the next clock
  assert_release_drops_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !ser_doe);
endmodule

// File: tb/tb_tws_reg_slave.sv
`timescale 1ns/1ps
module tb_tws_reg_slave;
  localparam int NREG = 16;
  localparam int MAXW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_doe;
  logic [NREG*MAXW-1:0] regs_flat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model of the default register map (R10 layout, widths from the brief)
  int          mw   [NREG] = '{10, 32, 8, 16, 1, 24, 12, 4, 0, 0, 0, 0, 0, 0, 0, 0};
  logic [31:0] mreg [NREG];

  always #2 clk = ~clk;

  tws_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe), .regs_flat(regs_flat)
  );

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [NREG*MAXW-1:0] act,
                       input logic [NREG*MAXW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*MAXW-1:0] model_bus();
    logic [NREG*MAXW-1:0] b = '0;
    for (int k = 0; k < NREG; k++) b[k*MAXW +: MAXW] = mreg[k];
    return b;
  endfunction

  function automatic logic exp_bit(input int a, input int i);
    if (mw[a] == 0) return (i < 32);
    if (i < mw[a]) return mreg[a][mw[a]-1-i];
    return 1'b0;
  endfunction

  task automatic send_bit(input logic b);
    ser_din = b;
    clk_wait(8); ser_clk = 1'b1;
    clk_wait(8); ser_clk = 1'b0;
  endtask

  task automatic send_header(input logic [3:0] a);
    ser_sel_n = 1'b0;
    clk_wait(8);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
  endtask

  // read n bits; n below the width is an abort (R7)
  task automatic do_read(input logic [3:0] a, input int n);
    string tag;
    send_header(a);
    ser_din = 1'b0;
    clk_wait(8); ser_clk = 1'b1;
    clk_wait(6);
    check(ser_doe == 1'b0, "R3 oe low in direction bit", ser_doe, 0);
    clk_wait(2); ser_clk = 1'b0;
    for (int i = 0; i < n; i++) begin
      clk_wait(7);
      if (i == 0) check(ser_doe == 1'b1, "R3 oe after direction fall", ser_doe, 1);
      if (mw[a] == 0)     tag = $sformatf("R6 addr %0d bit %0d", a, i);
      else if (i < mw[a]) tag = $sformatf("R4 addr %0d bit %0d", a, i);
      else                tag = $sformatf("R5 addr %0d bit %0d", a, i);
      check(ser_dout == exp_bit(a, i), tag, ser_dout, exp_bit(a, i));
      if (i < n - 1) begin
        clk_wait(1); ser_clk = 1'b1;
        clk_wait(8); ser_clk = 1'b0;
      end
    end
    clk_wait(1); ser_sel_n = 1'b1;
    clk_wait(8);
    check(ser_doe == 1'b0, "R7 oe released at frame end", ser_doe, 0);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [63:0] v, input int n,
                          input string tag);
    logic [31:0] m;
    send_header(a);
    send_bit(1'b1);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    check(ser_doe == 1'b0, "R9 oe low during write", ser_doe, 0);
    clk_wait(8); ser_sel_n = 1'b1;
    clk_wait(8);
    if (mw[a] != 0 && n == mw[a]) begin
      m = (mw[a] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << mw[a]) - 32'd1);
      mreg[a] = v[31:0] & m;
    end
    check(regs_flat == model_bus(), tag, regs_flat, model_bus());
  endtask

  task automatic t_reset;
    check(ser_doe == 1'b0, "R1 oe after reset", ser_doe, 0);
    check(ser_dout == 1'b0, "R1 dout after reset", ser_dout, 0);
    check(regs_flat == '0, "R1 registers after reset", regs_flat, 0);
  endtask

  task automatic t_short_reg;
    do_write(4'd0, 64'h2A5, 10, "R8 R10 write addr 0");
    do_read(4'd0, 13);
  endtask

  task automatic t_wide_reg;
    do_write(4'd1, 64'hDEAD_BEEF, 32, "R8 R10 write addr 1");
    do_read(4'd1, 34);
    do_write(4'd3, 64'h1_C3A5, 16, "R8 upper bits dropped addr 3");
    do_read(4'd3, 17);
  endtask

  task automatic t_one_bit_reg;
    do_write(4'd4, 64'h1, 1, "R8 write addr 4");
    do_read(4'd4, 3);
  endtask

  task automatic t_bad_read;
    do_read(4'd12, 36);
    do_read(4'd8, 33);
  endtask

  task automatic t_abort_read;
    do_read(4'd1, 5);
    do_read(4'd0, 10);
  endtask

  task automatic t_abort_header;
    ser_sel_n = 1'b0;
    clk_wait(8);
    send_bit(1'b1);
    send_bit(1'b0);
    clk_wait(4); ser_sel_n = 1'b1;
    clk_wait(8);
    check(ser_doe == 1'b0, "R7 oe after header abort", ser_doe, 0);
    do_write(4'd2, 64'h5A, 8, "R7 R2 write after header abort");
    do_read(4'd2, 8);
  endtask

  task automatic t_bad_writes;
    do_write(4'd2, 64'h11, 7, "R9 short write ignored");
    do_write(4'd2, 64'h1FF, 9, "R9 long write ignored");
    do_write(4'd10, 64'hFFFF_FFFF, 32, "R9 invalid address write ignored");
    do_read(4'd2, 9);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) mreg[k] = '0;
    clk_wait(5);
    rst_n = 1'b1;
    clk_wait(5);
    t_reset();
    t_short_reg();
    t_wide_reg();
    t_one_bit_reg();
    t_bad_read();
    t_abort_read();
    t_abort_header();
    t_bad_writes();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule